// File: doc/BRIEF.md
# Pixel Unpacker with Alpha Modifier

This block sits at the receive side of an image pipeline. Each accepted input word holds one pixel in one of several source formats. The block turns it into a uniform 32-bit alpha-red-green-blue pixel with eight bits per channel. Before decoding, two optional reorderings can be applied: a byte-pair exchange and a reversal of the colour components. After decoding, an alpha stage keeps, replaces or scales the alpha value and can then complement it.

Formats that carry only alpha take their colour from a 24-bit fixed-colour input. Palette formats do not produce a colour. They produce an 8-bit palette index, raise an index flag, and leave the lookup to an external table. All configuration inputs are static while a frame streams. The result leaves through a single registered stage with a valid/ready handshake. A format code the block does not support yields a zero pixel and sets an error flag that stays set until reset.

Top module: `pix_unpack_alpha`

## Requirements
- R1: Format codes are 0 = 32-bit ARGB, 1 = 24-bit RGB, 2 = 16-bit 5-6-5 RGB, 4 = 8-bit palette, 5 = 4-bit palette, 6 = 8-bit alpha, 7 = 4-bit alpha. In code 0 the word is A[31:24] R[23:16] G[15:8] B[7:0], and out_pixel uses that same layout.
- R2: In code 1 the input is R[23:16] G[15:8] B[7:0] and the source alpha is 255.
- R3: In code 2 the input is R[15:11] G[10:5] B[4:0] and the source alpha is 255. Each channel widens to 8 bits by copying its top bits into the vacated low bits.
- R4: When cfg_rgb_swap is set, the component order is reversed for codes 0, 1 and 2. Code 0 is then read as B[31:24] G[23:16] R[15:8] A[7:0], code 1 as B[23:16] G[15:8] R[7:0], and code 2 as B[15:11] G[10:5] R[4:0].
- R5: When cfg_byte_swap is set, bytes 0 and 1 trade places and bytes 2 and 3 trade places, before any other step. This applies to codes 0 and 2 only; every other code ignores it.
- R6: Codes 6 and 7 take R, G and B from cfg_fix_rgb[23:16], [15:8] and [7:0]. The source alpha is in_data[7:0] for code 6. For code 7 it is the nibble v = in_data[3:0], doubled as {v,v}.
- R7: Codes 4 and 5 output the index in_data[7:0] or in_data[3:0], zero-extended to 32 bits, with out_is_index = 1. The alpha stage does not touch index outputs. All other codes output out_is_index = 0.
- R8: cfg_alpha_mode 1 replaces the alpha with cfg_alpha_val. Modes 0 and 3 keep the source alpha.
- R9: cfg_alpha_mode 2 sets alpha = floor(source_alpha * cfg_alpha_val / 256).
- R10: With cfg_alpha_inv set, the alpha coming out of the mode step is bitwise complemented.
- R11: An accepted word with codes 3 or 8 to 15 produces out_pixel = 0 with out_is_index = 0 and sets err_sticky. err_sticky stays at 1 until reset.
- R12: in_ready is high when the output register is empty or being drained. A result appears on the cycle after acceptance. While out_valid is high and out_ready is low, out_pixel holds and in_ready is low.
- R13: After synchronous reset, out_valid = 0, err_sticky = 0 and in_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 4 | Source format code |
| cfg_rgb_swap | input | 1 | Reverse component order |
| cfg_byte_swap | input | 1 | Exchange bytes within each 16-bit half |
| cfg_alpha_mode | input | 2 | 0 keep, 1 replace, 2 scale, 3 keep |
| cfg_alpha_inv | input | 1 | Complement alpha after the mode step |
| cfg_alpha_val | input | 8 | Replacement value or scale factor |
| cfg_fix_rgb | input | 24 | Colour for alpha-only formats |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 32 | Raw input pixel word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pixel | output | 32 | ARGB result or zero-extended index |
| out_is_index | output | 1 | out_pixel holds a palette index |
| err_sticky | output | 1 | An unsupported code was accepted |

## Verification
The hardest condition to reach from the ports is a run of results that stall under back-pressure, with the format changing from one word to the next. Here a wrong hold or a lost word would show up only as a shifted result. The stimulus reaches it by driving out_ready from a random pattern during a long mixed-format burst. A scoreboard queue of expected pixels catches any reordering, duplication or change of a held value. The sticky error is checked by following an unsupported word with good words, confirming the flag stays set, and then applying reset.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    parameter int CH_W   = 8;
    parameter int MODE_W = 4;
    localparam int PIX_W = 4 * CH_W;
    localparam int RGB_W = 3 * CH_W;

    localparam logic [MODE_W-1:0] FMT_ARGB32 = 4'd0;
    localparam logic [MODE_W-1:0] FMT_RGB24  = 4'd1;
    localparam logic [MODE_W-1:0] FMT_RGB16  = 4'd2;
    localparam logic [MODE_W-1:0] FMT_PAL8   = 4'd4;
    localparam logic [MODE_W-1:0] FMT_PAL4   = 4'd5;
    localparam logic [MODE_W-1:0] FMT_ALF8   = 4'd6;
    localparam logic [MODE_W-1:0] FMT_ALF4   = 4'd7;

    typedef enum logic [1:0] {
        AM_KEEP  = 2'd0,
        AM_FIXED = 2'd1,
        AM_SCALE = 2'd2,
        AM_RSVD  = 2'd3
    } alpha_mode_e;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    typedef struct packed {
        argb_t px;
        logic  is_index;
        logic  bad;
    } unpacked_t;

    function automatic logic [PIX_W-1:0] pair_swap(input logic [PIX_W-1:0] w);
        return {w[23:16], w[31:24], w[7:0], w[15:8]};
    endfunction

    function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction
endpackage

// File: rtl/pxu_unpack.sv
module pxu_unpack
    import pxu_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              rgb_swap,
    input  logic              byte_swap,
    input  logic [RGB_W-1:0]  fix_rgb,
    input  logic [PIX_W-1:0]  data,
    output unpacked_t         res
);
    logic [PIX_W-1:0] w;
    logic [15:0]      h;
    logic [4:0]       r5, b5;

    always_comb begin
        w   = data;
        h   = data[15:0];
        r5  = '0;
        b5  = '0;
        res = '0;
        unique case (mode)
            FMT_ARGB32: begin
                if (byte_swap) w = pair_swap(data);
                if (rgb_swap) begin
                    res.px.b = w[31:24];
                    res.px.g = w[23:16];
                    res.px.r = w[15:8];
                    res.px.a = w[7:0];
                end else begin
                    res.px = argb_t'(w);
                end
            end
            FMT_RGB24: begin
                res.px.a = '1;
                res.px.g = data[15:8];
                res.px.r = rgb_swap ? data[7:0]   : data[23:16];
                res.px.b = rgb_swap ? data[23:16] : data[7:0];
            end
            FMT_RGB16: begin
                if (byte_swap) h = {data[7:0], data[15:8]};
                r5 = rgb_swap ? h[4:0]   : h[15:11];
                b5 = rgb_swap ? h[15:11] : h[4:0];
                res.px.a = '1;
                res.px.r = widen5(r5);
                res.px.g = widen6(h[10:5]);
                res.px.b = widen5(b5);
            end
            FMT_PAL8: begin
                res.px.b     = data[7:0];
                res.is_index = 1'b1;
            end
            FMT_PAL4: begin
                res.px.b     = {4'd0, data[3:0]};
                res.is_index = 1'b1;
            end
            FMT_ALF8: begin
                res.px.a = data[7:0];
                {res.px.r, res.px.g, res.px.b} = fix_rgb;
            end
            FMT_ALF4: begin
                res.px.a = {data[3:0], data[3:0]};
                {res.px.r, res.px.g, res.px.b} = fix_rgb;
            end
            default: res.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/pxu_alpha.sv
module pxu_alpha
    import pxu_pkg::*;
(
    input  alpha_mode_e       mode,
    input  logic              invert,
    input  logic [CH_W-1:0]   val,
    input  unpacked_t         src,
    output logic [PIX_W-1:0]  pixel,
    output logic              is_index
);
    logic [2*CH_W-1:0] prod;
    logic [CH_W-1:0]   a_mod;
    argb_t             px;

    always_comb begin
        prod = src.px.a * val;
        unique case (mode)
            AM_FIXED: a_mod = val;
            AM_SCALE: a_mod = prod[2*CH_W-1:CH_W];
            default:  a_mod = src.px.a;
        endcase
        px   = src.px;
        px.a = invert ? ~a_mod : a_mod;
        if (src.bad)
            pixel = '0;
        else if (src.is_index)
            pixel = src.px;
        else
            pixel = px;
        is_index = src.is_index && !src.bad;
    end
endmodule

// File: rtl/pxu_outstage.sv
module pxu_outstage #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pix_unpack_alpha.sv
module pix_unpack_alpha
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_rgb_swap,
    input  logic              cfg_byte_swap,
    input  logic [1:0]        cfg_alpha_mode,
    input  logic              cfg_alpha_inv,
    input  logic [CH_W-1:0]   cfg_alpha_val,
    input  logic [RGB_W-1:0]  cfg_fix_rgb,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_pixel,
    output logic              out_is_index,
    output logic              err_sticky
);
    unpacked_t        unp;
    logic [PIX_W-1:0] pix_c;
    logic             idx_c;

    pxu_unpack u_unpack (
        .mode      (cfg_mode),
        .rgb_swap  (cfg_rgb_swap),
        .byte_swap (cfg_byte_swap),
        .fix_rgb   (cfg_fix_rgb),
        .data      (in_data),
        .res       (unp)
    );

    pxu_alpha u_alpha (
        .mode     (alpha_mode_e'(cfg_alpha_mode)),
        .invert   (cfg_alpha_inv),
        .val      (cfg_alpha_val),
        .src      (unp),
        .pixel    (pix_c),
        .is_index (idx_c)
    );

    pxu_outstage #(.W(PIX_W + 1)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   ({idx_c, pix_c}),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  ({out_is_index, out_pixel})
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_sticky <= 1'b0;
        else if (in_valid && in_ready && unp.bad)
            err_sticky <= 1'b1;
    end
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_pixel,
    input logic        out_is_index,
    input logic        err_sticky
);
    // R12: a stalled result holds its value
    assert_hold_stall_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pixel) && $stable(out_is_index));

    // R12: no acceptance while the output register is blocked
    assert_block_input_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R12: an accepted word appears on the next cycle
    assert_accept_latency_R12: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    // R11: the error flag never clears without reset
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    // R7: index results carry nothing above the low byte
    assert_index_width_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_is_index |-> out_pixel[31:8] == 24'd0);
endmodule

bind pix_unpack_alpha pxu_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_pixel    (out_pixel),
    .out_is_index (out_is_index),
    .err_sticky   (err_sticky)
);

// File: tb/tb_pix_unpack_alpha.sv
`timescale 1ns/1ps
module tb_pix_unpack_alpha;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_mode = '0;
    logic        cfg_rgb_swap = 1'b0, cfg_byte_swap = 1'b0, cfg_alpha_inv = 1'b0;
    logic [1:0]  cfg_alpha_mode = '0;
    logic [7:0]  cfg_alpha_val = '0;
    logic [23:0] cfg_fix_rgb = '0;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid, out_ready = 1'b1;
    logic [31:0] out_pixel;
    logic        out_is_index, err_sticky;

    int checks = 0, errors = 0, cycles = 0;
    bit stall_en = 1'b0;
    bit done = 1'b0;

    typedef struct { logic [31:0] px; logic idx; string tag; } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    pix_unpack_alpha dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [32:0] model(input logic [3:0] m, input logic rs, input logic bs,
                                          input logic [1:0] am, input logic inv, input logic [7:0] v,
                                          input logic [23:0] fx, input logic [31:0] d);
        logic [7:0] a, r, g, b;
        logic [31:0] w;
        logic [15:0] h, p;
        logic [4:0] r5, b5;
        logic [5:0] g6;
        case (m)
            4'd0: begin
                w = bs ? {d[23:16], d[31:24], d[7:0], d[15:8]} : d;
                if (rs) {b, g, r, a} = w; else {a, r, g, b} = w;
            end
            4'd1: begin
                a = 8'hFF;
                if (rs) {b, g, r} = d[23:0]; else {r, g, b} = d[23:0];
            end
            4'd2: begin
                h = bs ? {d[7:0], d[15:8]} : d[15:0];
                if (rs) {b5, g6, r5} = h; else {r5, g6, b5} = h;
                a = 8'hFF;
                r = {r5, r5[4:2]};
                g = {g6, g6[5:4]};
                b = {b5, b5[4:2]};
            end
            4'd4: return {1'b1, 24'd0, d[7:0]};
            4'd5: return {1'b1, 28'd0, d[3:0]};
            4'd6: begin a = d[7:0]; {r, g, b} = fx; end
            4'd7: begin a = {d[3:0], d[3:0]}; {r, g, b} = fx; end
            default: return 33'd0;
        endcase
        if (am == 2'd1) a = v;
        else if (am == 2'd2) begin p = a * v; a = p[15:8]; end
        if (inv) a = ~a;
        return {1'b0, a, r, g, b};
    endfunction

    task automatic beat(input logic [31:0] d, input string tag);
        exp_t e;
        logic [32:0] m;
        m = model(cfg_mode, cfg_rgb_swap, cfg_byte_swap, cfg_alpha_mode, cfg_alpha_inv,
                  cfg_alpha_val, cfg_fix_rgb, d);
        e.px = m[31:0];
        e.idx = m[32];
        e.tag = tag;
        in_data = d;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic cfg(input logic [3:0] m, input logic rs, input logic bs,
                       input logic [1:0] am, input logic inv, input logic [7:0] v);
        cfg_mode = m; cfg_rgb_swap = rs; cfg_byte_swap = bs;
        cfg_alpha_mode = am; cfg_alpha_inv = inv; cfg_alpha_val = v;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // back-pressure driver
    always @(negedge clk) out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;

    // monitor / scoreboard
    logic [31:0] held_px;
    bit          held = 1'b0;
    always @(negedge clk) begin
        #2;
        if (!rst && out_valid) begin
            if (held) chk(out_pixel == held_px, "R12 hold", {32'd0, out_pixel}, {32'd0, held_px});
            if (out_ready) begin
                held = 1'b0;
                if (sb.size() == 0) begin
                    chk(1'b0, "R12 unexpected output", {32'd0, out_pixel}, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(out_pixel == e.px && out_is_index == e.idx, e.tag,
                        {31'd0, out_is_index, out_pixel}, {31'd0, e.idx, e.px});
                end
            end else begin
                chk(!in_ready, "R12 ready low while stalled", {63'd0, in_ready}, 64'd0);
                held = 1'b1;
                held_px = out_pixel;
            end
        end else begin
            held = 1'b0;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!out_valid && !err_sticky && in_ready, "R13 reset state",
            {61'd0, out_valid, err_sticky, in_ready}, 64'd1);
        @(negedge clk);

        cfg(4'd0, 0, 0, 2'd0, 0, 8'h00);
        beat(32'h80112233, "R1 argb passthrough");
        beat(32'h00FFEE01, "R1 argb low alpha");
        cfg(4'd1, 0, 0, 2'd0, 0, 8'h00);
        beat(32'h00A1B2C3, "R2 rgb24 alpha 255");
        beat(32'h5A010203, "R2 rgb24 top byte ignored");
        cfg(4'd2, 0, 0, 2'd0, 0, 8'h00);
        beat(32'h0000F81F, "R3 rgb16 magenta");
        beat(32'h000007E0, "R3 rgb16 green");
        beat(32'h00008410, "R3 rgb16 mid grey");
        cfg(4'd0, 1, 0, 2'd0, 0, 8'h00);
        beat(32'h11223344, "R4 argb component reverse");
        cfg(4'd1, 1, 0, 2'd0, 0, 8'h00);
        beat(32'h00A1B2C3, "R4 rgb24 component reverse");
        cfg(4'd2, 1, 0, 2'd0, 0, 8'h00);
        beat(32'h0000F800, "R4 rgb16 component reverse");
        cfg(4'd0, 0, 1, 2'd0, 0, 8'h00);
        beat(32'h11223344, "R5 argb byte pairs");
        cfg(4'd2, 0, 1, 2'd0, 0, 8'h00);
        beat(32'h000000F8, "R5 rgb16 byte pairs");
        cfg(4'd2, 1, 1, 2'd0, 0, 8'h00);
        beat(32'h00001F00, "R5 R4 rgb16 both swaps");
        cfg(4'd1, 0, 1, 2'd0, 0, 8'h00);
        beat(32'h00A1B2C3, "R5 rgb24 ignores byte swap");
        cfg_fix_rgb = 24'h123456;
        cfg(4'd6, 0, 1, 2'd0, 0, 8'h00);
        beat(32'hFFFF7F00 | 32'h0000007F, "R5 R6 alpha8 ignores byte swap");
        cfg(4'd7, 1, 0, 2'd0, 0, 8'h00);
        beat(32'h000000AC, "R6 alpha4 nibble doubled");
        cfg(4'd4, 1, 1, 2'd1, 1, 8'h33);
        beat(32'hDEADBEA7, "R7 pal8 index untouched by alpha");
        cfg(4'd5, 0, 0, 2'd2, 0, 8'h80);
        beat(32'hDEADBEE9, "R7 pal4 index");
        cfg(4'd0, 0, 0, 2'd1, 0, 8'h5C);
        beat(32'hF0102030, "R8 fixed alpha");
        cfg(4'd1, 0, 0, 2'd3, 0, 8'h5C);
        beat(32'h00102030, "R8 reserved mode keeps");
        cfg(4'd0, 0, 0, 2'd2, 0, 8'h80);
        beat(32'hC8000000, "R9 scale by half");
        cfg(4'd0, 0, 0, 2'd2, 0, 8'hFF);
        beat(32'hFF000000, "R9 scale full gives 254");
        cfg(4'd6, 0, 0, 2'd2, 0, 8'h00);
        beat(32'h000000FF, "R9 scale by zero");
        cfg(4'd0, 0, 0, 2'd0, 1, 8'h00);
        beat(32'h3C445566, "R10 invert kept alpha");
        cfg(4'd2, 0, 0, 2'd1, 1, 8'h0F);
        beat(32'h0000FFFF, "R10 invert after replace");
        drain();

        stall_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            logic [3:0] modes [7];
            modes = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7};
            cfg(modes[i % 7], i[0], i[1], 2'(i % 3), i[2], 8'(i * 37));
            beat($urandom, "R12 stalled mixed stream");
        end
        drain();
        stall_en = 1'b0;
        @(negedge clk);

        chk(!err_sticky, "R11 no error before bad code", {63'd0, err_sticky}, 64'd0);
        cfg(4'd3, 0, 0, 2'd1, 1, 8'h77);
        beat(32'hFFFFFFFF, "R11 code 3 gives zero");
        drain();
        chk(err_sticky, "R11 error set", {63'd0, err_sticky}, 64'd1);
        cfg(4'd0, 0, 0, 2'd0, 0, 8'h00);
        beat(32'h01020304, "R11 good word after error");
        cfg(4'd9, 0, 0, 2'd0, 0, 8'h00);
        beat(32'h12345678, "R11 code 9 gives zero");
        drain();
        chk(err_sticky, "R11 error stays set", {63'd0, err_sticky}, 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!err_sticky && !out_valid, "R11 R13 reset clears error",
            {62'd0, err_sticky, out_valid}, 64'd0);
        @(negedge clk);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule